// File: doc/BRIEF.md
# Fixed-point direct-form FIR filter

This block is a 15-tap real FIR filter of order 14 built in direct form. On every clock cycle with the enable high it accepts one signed 16-bit sample with 15 fractional bits. It forms the products of the current sample and the 14 stored samples with a parameter array of signed 16-bit coefficients, and it adds them without loss in a 40-bit accumulator. It then rounds the sum to a signed 16-bit result with 9 fractional bits and registers that result.

Rounding is convergent: the result goes to the nearest value, and an exact half goes to the even neighbour. The rounding shift is derived from a parameter, so the coefficient fractional length can change. When the rounded value does not fit in 16 bits, its upper bits are dropped and the output wraps, with no saturation. The filter sits in a sample-rate datapath. The surrounding logic gates it with the enable and reads one new output per enabled cycle.

Top module: `fir15_q9`

## Requirements
- R1: A synchronous reset (`srst` high at a rising edge) clears all 14 stored samples and the output register to zero.
- R2: At an edge with `ce` low and `srst` low, the output and every stored sample keep their values, whatever `smp_in` holds.
- R3: At an edge with `ce` high, the sample on `smp_in` enters stored position 0, and each stored position k moves to position k+1; the sample in position 13 is dropped.
- R4: After an enabled edge, `flt_out` equals the rounded sum of C[k]*x[n-k] for k = 0..14. Here x[n] is the value on `smp_in` at that edge and x[n-k] for k ≥ 1 is stored position k-1, so the latency is one enabled cycle.
- R5: Each product is kept as an exact 32-bit signed value. Each product is sign-extended to 40 bits before the sum, so no precision is lost for any input, including full-scale negative runs.
- R6: The sum is scaled down by 2^S, where S = 15 + COEF_FRAC − 9, with round-to-nearest and exact ties to even. Examples with S = 16 and an impulse of 0x8000: coefficient 1 gives 0x0000, 3 gives 0xFFFE, −5 gives 0x0002 and 7 gives 0xFFFC.
- R7: When the rounded value is outside the signed 16-bit range, `flt_out` holds its low 16 bits (two's-complement wrap), not a saturated value.
- R8: An impulse of 0x7FFF followed by zeros makes `flt_out` give, on successive enabled cycles, the values round(C[k]*32767 / 2^S) for k = 0..14, and then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; the filter advances only when high |
| smp_in | input | 16 | Input sample, signed, 15 fractional bits |
| flt_out | output | 16 | Filtered result, signed, 9 fractional bits, registered |

## Verification
Exact rounding ties are the hardest case to reach from the ports. With 21 bits discarded and random data, a sum whose discarded part is exactly one half almost never occurs. The bench therefore builds a second instance with a coefficient fractional length of 10 and small odd coefficients. An impulse of 0x8000 then places every such product exactly on a half, which exercises both tie directions. The same instance has large coefficients, so a full-scale step drives the rounded sum far beyond 16 bits and shows the wrap.

// File: rtl/fir15_pkg.sv
package fir15_pkg;

    localparam int unsigned SMP_W  = 16;
    localparam int unsigned SMP_FR = 15;
    localparam int unsigned OUT_W  = 16;
    localparam int unsigned OUT_FR = 9;
    localparam int unsigned ACC_W  = 40;

    // Bits dropped when moving from the accumulator grid to the output grid.
    function automatic int unsigned drop_bits(input int unsigned in_fr,
                                              input int unsigned cf_fr,
                                              input int unsigned out_fr);
        return in_fr + cf_fr - out_fr;
    endfunction

endpackage

// File: rtl/fir15_line.sv
module fir15_line #(
    parameter int unsigned NDLY = 14,
    parameter int unsigned W    = 16
) (
    input  logic                      clk,
    input  logic                      srst,
    input  logic                      ce,
    input  logic [W-1:0]              din,
    output logic [NDLY-1:0][W-1:0]    dly
);

    always_ff @(posedge clk) begin
        if (srst) begin
            dly <= '0;
        end else if (ce) begin
            dly[0] <= din;
            for (int k = 1; k < NDLY; k++) begin
                dly[k] <= dly[k-1];
            end
        end
    end

endmodule

// File: rtl/fir15_mac.sv
module fir15_mac #(
    parameter int unsigned NTAPS = 15,
    parameter int unsigned W     = 16,
    parameter int unsigned CW    = 16,
    parameter int unsigned AW    = 40,
    parameter logic signed [CW-1:0] COEF [NTAPS] = '{default: '0}
) (
    input  logic [W-1:0]                 cur,
    input  logic [NTAPS-2:0][W-1:0]      dly,
    output logic signed [AW-1:0]         acc
);

    localparam int unsigned PW = W + CW;

    logic signed [PW-1:0] prod [NTAPS];

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            if (k == 0) begin : g_cur
                assign prod[k] = $signed(cur) * COEF[k];
            end else begin : g_old
                assign prod[k] = $signed(dly[k-1]) * COEF[k];
            end
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) begin
            acc = acc + {{(AW-PW){prod[k][PW-1]}}, prod[k]};
        end
    end

endmodule

// File: rtl/fir15_round.sv
module fir15_round #(
    parameter int unsigned AW = 40,
    parameter int unsigned OW = 16,
    parameter int unsigned SH = 21
) (
    input  logic signed [AW-1:0] acc,
    output logic [OW-1:0]        res
);

    localparam logic [SH-1:0] HALF = {1'b1, {(SH-1){1'b0}}};

    logic signed [AW-1:0] quo;
    logic [SH-1:0]        frac;
    logic                 bump;

    always_comb begin
        quo  = acc >>> SH;
        frac = acc[SH-1:0];
        bump = (frac > HALF) || ((frac == HALF) && quo[0]);
        res  = quo[OW-1:0] + {{(OW-1){1'b0}}, bump};
    end

endmodule

// File: rtl/fir15_q9.sv
module fir15_q9 #(
    parameter int unsigned NTAPS     = 15,
    parameter int unsigned COEF_W    = 16,
    parameter int unsigned COEF_FRAC = 15,
    parameter logic signed [COEF_W-1:0] COEF [NTAPS] = '{
        -16'sd120, -16'sd310, 16'sd0, 16'sd980, 16'sd2450, 16'sd4300, 16'sd5900, 16'sd6540,
        16'sd5900, 16'sd4300, 16'sd2450, 16'sd980, 16'sd0, -16'sd310, -16'sd120}
) (
    input  logic        clk,
    input  logic        srst,
    input  logic        ce,
    input  logic [15:0] smp_in,
    output logic [15:0] flt_out
);

    import fir15_pkg::*;

    localparam int unsigned NDLY = NTAPS - 1;
    localparam int unsigned SH   = drop_bits(SMP_FR, COEF_FRAC, OUT_FR);

    logic [NDLY-1:0][SMP_W-1:0] dly_q;
    logic signed [ACC_W-1:0]    acc_c;
    logic [OUT_W-1:0]           res_c;

    fir15_line #(.NDLY(NDLY), .W(SMP_W)) u_line (
        .clk (clk),
        .srst(srst),
        .ce  (ce),
        .din (smp_in),
        .dly (dly_q)
    );

    fir15_mac #(.NTAPS(NTAPS), .W(SMP_W), .CW(COEF_W), .AW(ACC_W), .COEF(COEF)) u_mac (
        .cur(smp_in),
        .dly(dly_q),
        .acc(acc_c)
    );

    fir15_round #(.AW(ACC_W), .OW(OUT_W), .SH(SH)) u_rnd (
        .acc(acc_c),
        .res(res_c)
    );

    always_ff @(posedge clk) begin
        if (srst) begin
            flt_out <= '0;
        end else if (ce) begin
            flt_out <= res_c;
        end
    end

endmodule

// File: rtl/fir15_q9_chk.sv
module fir15_q9_chk #(
    parameter int unsigned NDLY = 14,
    parameter int unsigned W    = 16
) (
    input logic                   clk,
    input logic                   srst,
    input logic                   ce,
    input logic [W-1:0]           smp_in,
    input logic [15:0]            flt_out,
    input logic [NDLY-1:0][W-1:0] dly
);

    p_reset_clear_r1: assert property (@(posedge clk)
        srst |=> (flt_out == '0 && dly == '0));

    p_hold_out_r2: assert property (@(posedge clk) disable iff (srst)
        (!ce && !srst) |=> $stable(flt_out));

    p_hold_line_r2: assert property (@(posedge clk) disable iff (srst)
        (!ce && !srst) |=> $stable(dly));

    p_enter_r3: assert property (@(posedge clk) disable iff (srst)
        (ce && !srst) |=> dly[0] == $past(smp_in));

    p_shift_r3: assert property (@(posedge clk) disable iff (srst)
        (ce && !srst) |=> dly[NDLY-1:1] == $past(dly[NDLY-2:0]));

    p_quiet_r4: assert property (@(posedge clk) disable iff (srst)
        (ce && !srst && smp_in == '0 && dly == '0) |=> flt_out == '0);

endmodule

bind fir15_q9 fir15_q9_chk #(.NDLY(NDLY), .W(SMP_W)) u_chk (
    .clk    (clk),
    .srst   (srst),
    .ce     (ce),
    .smp_in (smp_in),
    .flt_out(flt_out),
    .dly    (dly_q)
);

// File: tb/sim_fir15_q9.sv
module sim_fir15_q9;

    localparam int CF0 = 15;
    localparam int CF1 = 10;

    localparam logic signed [15:0] K1 [15] = '{
        16'sd1, 16'sd3, -16'sd5, 16'sd7, 16'sd30001, -16'sd29999, 16'sd31001, 16'sd32767,
        16'sd31001, -16'sd29999, 16'sd30001, 16'sd7, -16'sd5, 16'sd3, 16'sd1};

    int c0 [15] = '{-120, -310, 0, 980, 2450, 4300, 5900, 6540, 5900, 4300, 2450, 980, 0, -310, -120};
    int c1 [15] = '{1, 3, -5, 7, 30001, -29999, 31001, 32767, 31001, -29999, 30001, 7, -5, 3, 1};

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        ce = 1'b0;
    logic [15:0] smp_in = '0;
    logic [15:0] y0, y1;

    int total = 0;
    int bad = 0;
    int hist [15];
    bit done = 0;

    always #10 clk = ~clk;

    fir15_q9 u0 (.clk(clk), .srst(srst), .ce(ce), .smp_in(smp_in), .flt_out(y0));

    fir15_q9 #(.COEF_FRAC(CF1), .COEF(K1)) u1 (
        .clk(clk), .srst(srst), .ce(ce), .smp_in(smp_in), .flt_out(y1));

    function automatic logic [15:0] model(input int c [15], input int cf, input int h [15]);
        longint s = 0;
        longint q, r, hf;
        int sh;
        for (int k = 0; k < 15; k++) s += longint'(c[k]) * longint'(h[k]);
        sh = 15 + cf - 9;
        q  = s >>> sh;
        r  = s - (q <<< sh);
        hf = longint'(1) <<< (sh - 1);
        if (r > hf || (r == hf && q[0])) q++;
        return q[15:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [15:0] xv, input logic e, input string req);
        smp_in = xv;
        ce = e;
        @(posedge clk);
        #1;
        if (e) begin
            for (int k = 14; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = int'($signed(xv));
        end
        chk({req, " u0"}, y0, model(c0, CF0, hist));
        chk({req, " u1"}, y1, model(c1, CF1, hist));
    endtask

    task automatic do_reset();
        srst = 1'b1;
        ce = 1'b0;
        @(posedge clk);
        #1;
        foreach (hist[k]) hist[k] = 0;
        chk("R1 reset u0", y0, 16'h0000);
        chk("R1 reset u1", y1, 16'h0000);
        srst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        foreach (hist[k]) hist[k] = 0;
        repeat (2) @(posedge clk);
        #1;
        do_reset();

        // R8 impulse response of u0
        cyc(16'h7FFF, 1'b1, "R8 impulse");
        for (int i = 0; i < 15; i++) cyc(16'h0000, 1'b1, "R8 impulse tail");

        // R6 ties to even on u1 (S = 16)
        cyc(16'h8000, 1'b1, "R6 tie");
        chk("R6 tie c=1", y1, 16'h0000);
        cyc(16'h0000, 1'b1, "R6 tie");
        chk("R6 tie c=3", y1, 16'hFFFE);
        cyc(16'h0000, 1'b1, "R6 tie");
        chk("R6 tie c=-5", y1, 16'h0002);
        cyc(16'h0000, 1'b1, "R6 tie");
        chk("R6 tie c=7", y1, 16'hFFFC);
        for (int i = 0; i < 12; i++) cyc(16'h0000, 1'b1, "R6 tie tail");

        // R2 hold with random input, then R3 continuation
        for (int i = 0; i < 5; i++) cyc(16'(i * 4099 + 17), 1'b1, "R4 load");
        for (int i = 0; i < 20; i++) cyc(16'($urandom), 1'b0, "R2 hold");
        for (int i = 0; i < 15; i++) cyc(16'h0000, 1'b1, "R3 resume");

        // R7 wrap under full-scale step on u1
        for (int i = 0; i < 20; i++) cyc(16'h7FFF, 1'b1, "R7 step");
        for (int i = 0; i < 20; i++) cyc(16'h8000, 1'b1, "R5 neg fullscale");

        do_reset();

        // R4 / R5 random traffic with random enable
        for (int i = 0; i < 3000; i++) begin
            cyc(16'($urandom), ($urandom % 5) != 0, "R4 random");
            if (i == 1500) do_reset();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule